// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port controlled through a small register bus. Software sets up each pin separately. A pin can be an input, or an output that the port drives. It can also be handed over to a peripheral, which then supplies the drive level and the output enable for that pin. Each pin's incoming level passes through a synchroniser. The result can be read back, and it feeds a per-pin edge detector.

Each pin can detect either a rising transition or a falling transition. When the selected transition occurs and interrupt is enabled for that pin, a sticky flag is set. Software clears a flag by writing 0 to it and can set one by writing 1. A single interrupt request output is high while any enabled pin has a pending flag.

Registers are reached through a select, write strobe, 3-bit address and 8-bit data bus. Writes take effect on the clock edge. Read data is combinational from the current address. Register addresses: 0 input level (read only), 1 output level, 2 direction, 3 function select, 4 edge select, 5 interrupt enable, 6 interrupt flag, 7 unmapped.

Top module: `gpio_edge_port`

## Requirements
- R1: While reset is asserted and after it, every register reads 0, every pin output enable is 0 and the interrupt request is 0.
- R2: Address 0 reads the pin levels delayed by a two-flop synchroniser: a pin change made between clock edges E0 and E1 is first visible after edge E2. Writes to address 0 have no effect.
- R3: With the function-select bit at 0, the pin output enable equals its direction bit (1 = output) and the pin drive equals its output-register bit.
- R4: With the function-select bit at 1, the pin drive and output enable follow the peripheral's drive and enable for that pin.
- R5: With the edge-select bit at 0 and enable at 1, a low-to-high transition of the synchronised level sets the pin's flag on the edge after the new level appears at address 0.
- R6: With the edge-select bit at 1 and enable at 1, a high-to-low transition sets the flag with the same timing as R5.
- R7: A pin held at a constant level never sets its flag. A transition on a pin whose enable bit is 0 leaves its flag unchanged.
- R8: Writing to address 6 replaces the flags with the written bits, so 0 clears and 1 sets. A qualifying edge in the same cycle as a clearing write leaves that flag set.
- R9: The interrupt request is high exactly when some pin has both its flag and its enable bit at 1.
- R10: Address 7 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Pin levels from the pads |
| periph_out | input | 8 | Peripheral drive level per pin |
| periph_oe | input | 8 | Peripheral output enable per pin |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_out | output | 8 | Drive level per pin |
| pad_oe | output | 8 | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that a write to address 6 is the only source of flag bits besides a change in the synchronised level. They also assume the bus holds its strobe and data stable for a whole clock period. The stimulus meets this by changing pins and bus signals only shortly after a rising edge and holding them for at least one full cycle. It also uses a clearing write that lands exactly in the cycle where an edge is being detected, which exercises the priority case inside these limits.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  periph_out,
  input  logic [WIDTH-1:0]  periph_oe,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FSEL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ES   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(6);

  logic [WIDTH-1:0] sync1_q, sync2_q, sync3_q;
  logic [WIDTH-1:0] out_q, dir_q, fsel_q, es_q, ie_q, flag_q;
  logic [WIDTH-1:0] rise, fall, edge_evt;
  logic             wr_en;

  assign wr_en    = bus_sel & bus_wr;
  assign rise     = sync2_q & ~sync3_q;
  assign fall     = ~sync2_q & sync3_q;
  assign edge_evt = ie_q & ((~es_q & rise) | (es_q & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      sync3_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      fsel_q <= '0;
      es_q   <= '0;
      ie_q   <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_OUT:   out_q  <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_FSEL:  fsel_q <= bus_wdata;
        A_ES:    es_q   <= bus_wdata;
        A_IE:    ie_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= ((wr_en && bus_addr == A_FLAG) ? bus_wdata : flag_q) | edge_evt;
  end

  always_comb begin
    case (bus_addr)
      A_IN:    bus_rdata = sync2_q;
      A_OUT:   bus_rdata = out_q;
      A_DIR:   bus_rdata = dir_q;
      A_FSEL:  bus_rdata = fsel_q;
      A_ES:    bus_rdata = es_q;
      A_IE:    bus_rdata = ie_q;
      A_FLAG:  bus_rdata = flag_q;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_out[i] = fsel_q[i] ? periph_out[i] : out_q[i];
    assign pad_oe[i]  = fsel_q[i] ? periph_oe[i]  : dir_q[i];
  end

  assign irq = |(flag_q & ie_q);

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  pad_oe,
  input logic              irq,
  input logic [WIDTH-1:0]  sync2_q,
  input logic [WIDTH-1:0]  sync3_q,
  input logic [WIDTH-1:0]  ie_q,
  input logic [WIDTH-1:0]  flag_q
);

  logic             flag_wr;
  logic [WIDTH-1:0] set_mask, clr_mask, lvl_chg;

  assign flag_wr  = bus_sel && bus_wr && bus_addr == ADDR_W'(6);
  assign set_mask = flag_wr ? bus_wdata : '0;
  assign clr_mask = flag_wr ? ~bus_wdata : '0;
  assign lvl_chg  = sync2_q ^ sync3_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!irq && pad_oe == '0 && flag_q == '0);
    end
  end

  p_flag_needs_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_q & ~$past(flag_q) & ~$past(set_mask) & ~$past(lvl_chg)) == '0);

  p_flag_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_q & ~$past(flag_q) & ~$past(set_mask) & ~$past(ie_q)) == '0);

  p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> (flag_q & $past(clr_mask) & ~$past(lvl_chg)) == '0);

  p_irq_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q != '0);

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_oe(pad_oe), .irq(irq),
  .sync2_q(sync2_q), .sync3_q(sync3_q), .ie_q(ie_q), .flag_q(flag_q)
);

// File: tb/gpio_edge_port_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_port_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] pin_in = 0, periph_out = 0, periph_oe = 0, bus_wdata = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_rdata, pad_out, pad_oe;
  logic       irq;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] hist[$];
  logic [7:0] m_out, m_dir, m_fsel, m_es, m_ie, m_flag;
  string phase = "R1";

  always #2 clk = ~clk;

  gpio_edge_port dut_i (.*);

  task automatic model_reset();
    hist = {8'h00, 8'h00, 8'h00};
    m_out = 0; m_dir = 0; m_fsel = 0; m_es = 0; m_ie = 0; m_flag = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      logic [7:0] lvl, prv, ev;
      lvl = hist[1]; prv = hist[2];
      for (int i = 0; i < 8; i++)
        ev[i] = m_ie[i] && (m_es[i] ? (prv[i] && !lvl[i]) : (!prv[i] && lvl[i]));
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          3'd1: m_out = bus_wdata;
          3'd2: m_dir = bus_wdata;
          3'd3: m_fsel = bus_wdata;
          3'd4: m_es = bus_wdata;
          3'd5: m_ie = bus_wdata;
          default: ;
        endcase
      end
      m_flag = ((bus_sel && bus_wr && bus_addr == 3'd6) ? bus_wdata : m_flag) | ev;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return hist[1];
      3'd1: return m_out;
      3'd2: return m_dir;
      3'd3: return m_fsel;
      3'd4: return m_es;
      3'd5: return m_ie;
      3'd6: return m_flag;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] e_out, e_oe;
    e_out = (m_fsel & periph_out) | (~m_fsel & m_out);
    e_oe  = (m_fsel & periph_oe) | (~m_fsel & m_dir);
    chk(!rst_n ? "R1" : "R3 pad_out", pad_out, e_out);
    chk(!rst_n ? "R1" : "R4 pad_oe", pad_oe, e_oe);
    chk(!rst_n ? "R1" : "R9 irq", {7'd0, irq}, {7'd0, |(m_flag & m_ie)});
    chk(!rst_n ? "R1" : tag_of(bus_addr), bus_rdata, m_read(bus_addr));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) tick(); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    tick(); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick(); bus_sel = 0; bus_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a);
    tick(); bus_sel = 1; bus_wr = 0; bus_addr = a; tick(); bus_sel = 0;
  endtask

  initial begin
    for (int a = 0; a < 8; a++) begin bus_addr = 3'(a); idle(1); end // R1 reset reads
    tick(); rst_n = 1;
    for (int a = 0; a < 8; a++) rd(3'(a));                  // R1 after reset
    wr(3'd2, 8'hF0); wr(3'd1, 8'hA5); rd(3'd1);             // R3
    wr(3'd0, 8'hFF); rd(3'd0);                              // R2 write ignored
    pin_in = 8'h3C; bus_addr = 3'd0; idle(4);               // R2 latency
    pin_in = 8'hC3; idle(1); pin_in = 8'h81; idle(3);
    periph_out = 8'h5A; periph_oe = 8'h33;
    wr(3'd3, 8'h0F); idle(2); periph_out = 8'hA6; idle(2);  // R4
    wr(3'd3, 8'h00);
    pin_in = 8'h00; idle(4);
    wr(3'd4, 8'hF0); wr(3'd5, 8'hFF); bus_addr = 3'd6;
    pin_in = 8'h0F; idle(5);                                // R5 rising on low nibble
    pin_in = 8'h00; idle(5);                                // R6 falling sets high nibble? no: high held
    pin_in = 8'hF0; idle(5); pin_in = 8'h00; idle(5);       // R6 falling on high nibble
    wr(3'd6, 8'h00); bus_addr = 3'd6; idle(20);             // R7 static level, R8 clear
    wr(3'd5, 8'h0F); pin_in = 8'hFF; idle(5);               // R7 disabled pins
    pin_in = 8'h00; idle(5);
    wr(3'd6, 8'h80); idle(2); wr(3'd6, 8'h00);              // R8 software set then clear
    pin_in = 8'h01; tick(); wr(3'd6, 8'h00); bus_addr = 3'd6; idle(3); // R8 edge wins
    wr(3'd5, 8'h00); idle(2); wr(3'd5, 8'h01); idle(2);     // R9 follows enable
    wr(3'd7, 8'hFF); for (int a = 0; a < 8; a++) rd(3'(a)); // R10
    for (int k = 0; k < 40; k++) begin
      pin_in = 8'(k * 37 + 11); bus_addr = 3'(k % 8);
      if (k % 9 == 0) wr(3'd6, 8'(k)); else idle(2);
    end
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule